// File: doc/BRIEF.md
# Packed-Element Lane ALU

This block is one 32-bit lane of a vector datapath. For every operation it treats its operands as one 32-bit element, two 16-bit elements or four 8-bit elements, depending on a mode input that may change with each operation. Narrow elements stay packed in the word, so storage around the lane keeps its dense layout.

A one-bit condition flag travels with every element. The flag takes a ninth bit beside a byte, so the lane word is four 9-bit slots, 36 bits in all. Add and subtract report their carry or borrow in that flag. Compares write only the flag. The lane also provides bitwise logic and a multiply that returns the low half of each product. All element widths share one array of byte partial products.

The lane is a two-stage pipeline. An operation presented with `in_valid` appears on `result` with `out_valid` two clock edges later. Between valid operations, `result` holds its last value.

Top module: `simd_lane_alu`

## Requirements
- R1: `mode` selects the element split: 2'b00 is one 32-bit element, 2'b01 is two 16-bit elements, and 2'b10 and 2'b11 are four 8-bit elements. No carry, borrow or equality crosses an element border.
- R2: Byte k of a word occupies bits [9k+7:9k] and its flag bit is 9k+8. An element's flag sits in the flag bit of its highest byte. All other flag bits of `result` are zero, and the flag bits of `src_a`/`src_b` are ignored.
- R3: `op`=0 (add) gives each element's sum modulo 2^width in the data bits and its carry-out in the flag.
- R4: `op`=1 (subtract a minus b) gives the difference modulo 2^width and sets the flag when a < b unsigned, which is the borrow.
- R5: `op`=2, 3 and 4 give the bitwise AND, OR and XOR of the data bits, with all flags zero.
- R6: `op`=5 (equal) sets each element's flag when its a and b elements are equal. All data bits are zero.
- R7: `op`=6 (less-than signed) sets each element's flag when a < b as two's-complement numbers. All data bits are zero.
- R8: `op`=7 (multiply) gives the low `width` bits of each element's unsigned product, with all flags zero.
- R9: `out_valid` rises exactly two rising edges after an operation is presented with `in_valid`, and one result appears per accepted operation, in order.
- R10: After reset, `result` and `out_valid` are zero. While no valid result is produced, `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| mode | input | 2 | Element split select |
| op | input | 3 | Operation code |
| src_a | input | 36 | First packed operand with flag slots |
| src_b | input | 36 | Second packed operand with flag slots |
| out_valid | output | 1 | `result` carries a new operation |
| result | output | 36 | Packed result with per-element flags |

## Verification
The bench sweeps every byte value of operand a against a set of edge bytes (0, 1, 0x7F, 0x80, 0xFF and others) in byte mode. It also sends random and edge words in the halfword and word modes, with random garbage in the input flag slots.

A carry that leaks across a byte border would corrupt the next element's sum. A borrow placed in the wrong flag slot, or a nonzero flag in an unused slot, would show up as a wrong packed word. Less-than built from the raw difference sign would fail when 0x7F is compared with 0x80. A multiply that mixes cross-byte products in byte or halfword mode would produce wrong low halves.

The bench checks that each result appears exactly two cycles after its operation is issued. During idle gaps it checks that the held value does not change.

// File: rtl/simd_lane_alu.sv
module simd_lane_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [1:0]  mode,
  input  logic [2:0]  op,
  input  logic [35:0] src_a,
  input  logic [35:0] src_b,
  output logic        out_valid,
  output logic [35:0] result
);
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2, OP_OR = 3'd3,
                         OP_XOR = 3'd4, OP_EQ = 3'd5, OP_LT = 3'd6, OP_MUL = 3'd7;

  logic [31:0] a_dat, b_dat;
  always_comb
    for (int k = 0; k < 4; k++) begin
      a_dat[8*k +: 8] = src_a[9*k +: 8];
      b_dat[8*k +: 8] = src_b[9*k +: 8];
    end

  logic        v1;
  logic [1:0]  m1;
  logic [2:0]  op1;
  logic [31:0] a1, b1;
  always_ff @(posedge clk)
    if (!rst_n) begin
      v1 <= 1'b0; m1 <= '0; op1 <= '0; a1 <= '0; b1 <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        m1 <= mode; op1 <= op; a1 <= a_dat; b1 <= b_dat;
      end
    end

  wire is8  = m1[1];
  wire is16 = (m1 == 2'b01);
  wire [3:0] first = {is8, is8 | is16, is8, 1'b1};
  wire [3:0] last  = {1'b1, is8, is8 | is16, is8};
  wire sub_n = (op1 == OP_SUB) || (op1 == OP_LT);

  logic [31:0] sum;
  logic [3:0]  co, eqv, lt;
  always_comb begin : chain
    logic c, er;
    logic [8:0] s;
    logic [7:0] bb;
    c = 1'b0; er = 1'b0;
    for (int k = 0; k < 4; k++) begin
      bb = sub_n ? ~b1[8*k +: 8] : b1[8*k +: 8];
      s  = {1'b0, a1[8*k +: 8]} + {1'b0, bb} + {8'd0, first[k] ? sub_n : c};
      sum[8*k +: 8] = s[7:0];
      c  = s[8];
      co[k] = c;
      er = (first[k] ? 1'b1 : er) & (a1[8*k +: 8] == b1[8*k +: 8]);
      eqv[k] = er;
      lt[k] = (a1[8*k+7] ^ b1[8*k+7]) ? a1[8*k+7] : s[7];
    end
  end

  logic [15:0] pp [4][4];
  always_comb
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        pp[i][j] = a1[8*i +: 8] * b1[8*j +: 8];

  logic [31:0] p32, p16, p8;
  always_comb begin
    p32 = '0;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        if (i + j < 4) p32 = p32 + (32'(pp[i][j]) << (8 * (i + j)));
    p16[15:0]  = pp[0][0] + {pp[0][1][7:0] + pp[1][0][7:0], 8'h00};
    p16[31:16] = pp[2][2] + {pp[2][3][7:0] + pp[3][2][7:0], 8'h00};
    for (int k = 0; k < 4; k++) p8[8*k +: 8] = pp[k][k][7:0];
  end

  logic [31:0] d;
  logic [3:0]  f;
  always_comb begin
    d = '0; f = '0;
    case (op1)
      OP_ADD: begin d = sum; f = co & last; end
      OP_SUB: begin d = sum; f = ~co & last; end
      OP_AND: d = a1 & b1;
      OP_OR:  d = a1 | b1;
      OP_XOR: d = a1 ^ b1;
      OP_EQ:  f = eqv & last;
      OP_LT:  f = lt & last;
      default: d = is8 ? p8 : (is16 ? p16 : p32);
    endcase
  end

  logic [35:0] res_n;
  always_comb
    for (int k = 0; k < 4; k++) res_n[9*k +: 9] = {f[k], d[8*k +: 8]};

  always_ff @(posedge clk)
    if (!rst_n) begin
      out_valid <= 1'b0; result <= '0;
    end else begin
      out_valid <= v1;
      if (v1) result <= res_n;
    end

  assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |=> out_valid);
  assert_valid_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(v1));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !v1 |=> $stable(result));
  assert_cmp_data_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && (op1 == OP_EQ || op1 == OP_LT)) |=>
    ({result[34:27], result[25:18], result[16:9], result[7:0]} == 32'd0));
  assert_unused_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && m1 == 2'b00) |=> (result[26] == 1'b0 && result[17] == 1'b0 && result[8] == 1'b0));
  assert_logic_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && (op1 == OP_AND || op1 == OP_OR || op1 == OP_XOR || op1 == OP_MUL)) |=>
    ({result[35], result[26], result[17], result[8]} == 4'd0));
endmodule

// File: tb/simd_lane_alu_test.sv
`timescale 1ns/1ps
module simd_lane_alu_test;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [1:0] mode = '0;
  logic [2:0] op = '0;
  logic [35:0] src_a = '0, src_b = '0;
  logic out_valid;
  logic [35:0] result;

  simd_lane_alu uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .op(op),
                     .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0, have_last = 0;
  logic [35:0] last_res;
  logic [35:0] q_exp[$];
  int q_t[$];
  logic [2:0] q_o[$];
  logic [1:0] q_m[$];

  function automatic logic [35:0] pack(input logic [31:0] dv, input logic [3:0] fv);
    logic [35:0] w;
    for (int k = 0; k < 4; k++) w[9*k +: 9] = {fv[k], dv[8*k +: 8]};
    return w;
  endfunction

  function automatic logic [31:0] dat(input logic [35:0] w);
    logic [31:0] dv;
    for (int k = 0; k < 4; k++) dv[8*k +: 8] = w[9*k +: 8];
    return dv;
  endfunction

  function automatic logic [35:0] model(input logic [1:0] m, input logic [2:0] o,
                                        input logic [35:0] a, input logic [35:0] b);
    int ew, n;
    longint mask, x, y, sx, sy, r;
    logic [31:0] dv;
    logic [3:0] fv;
    ew = (m == 2'b00) ? 32 : (m == 2'b01) ? 16 : 8;
    n = 32 / ew;
    mask = (longint'(1) << ew) - 1;
    dv = '0; fv = '0;
    for (int e = 0; e < n; e++) begin
      x = (longint'(dat(a)) >> (e * ew)) & mask;
      y = (longint'(dat(b)) >> (e * ew)) & mask;
      sx = (x >= (longint'(1) << (ew - 1))) ? x - (longint'(1) << ew) : x;
      sy = (y >= (longint'(1) << (ew - 1))) ? y - (longint'(1) << ew) : y;
      r = 0;
      case (o)
        3'd0: begin r = x + y; fv[(e+1)*(ew/8)-1] = ((r >> ew) & 1) != 0; end
        3'd1: begin r = x - y; fv[(e+1)*(ew/8)-1] = (x < y); end
        3'd2: r = x & y;
        3'd3: r = x | y;
        3'd4: r = x ^ y;
        3'd5: fv[(e+1)*(ew/8)-1] = (x == y);
        3'd6: fv[(e+1)*(ew/8)-1] = (sx < sy);
        default: r = x * y;
      endcase
      dv = dv | (32'(r & mask) << (e * ew));
    end
    return pack(dv, fv);
  endfunction

  function automatic string tag(input logic [2:0] o);
    case (o)
      3'd0: return "R3 R1 R2";
      3'd1: return "R4 R1 R2";
      3'd2, 3'd3, 3'd4: return "R5 R1 R2";
      3'd5: return "R6 R1 R2";
      3'd6: return "R7 R1 R2";
      default: return "R8 R1 R2";
    endcase
  endfunction

  task automatic check_out();
    if (out_valid) begin
      checks++;
      if (q_exp.size() == 0) begin
        errors++; $display("FAIL R9 unexpected out_valid got=1 exp=0");
      end else begin
        logic [35:0] e; int t; logic [2:0] o; logic [1:0] m;
        e = q_exp.pop_front(); t = q_t.pop_front(); o = q_o.pop_front(); m = q_m.pop_front();
        if (result !== e) begin
          errors++; $display("FAIL %s mode=%0d op=%0d got=%h exp=%h", tag(o), m, o, result, e);
        end
        checks++;
        if (cyc != t + 2) begin
          errors++; $display("FAIL R9 latency got=%0d exp=2", cyc - t);
        end
      end
      last_res = result; have_last = 1;
    end else begin
      if (q_t.size() > 0 && cyc >= q_t[0] + 2) begin
        checks++; errors++;
        $display("FAIL R9 missing out_valid got=0 exp=1");
        void'(q_exp.pop_front()); void'(q_t.pop_front()); void'(q_o.pop_front()); void'(q_m.pop_front());
      end
      if (have_last) begin
        checks++;
        if (result !== last_res) begin
          errors++; $display("FAIL R10 hold got=%h exp=%h", result, last_res);
        end
      end
    end
  endtask

  task automatic step(input bit drv, input logic [1:0] m, input logic [2:0] o,
                      input logic [35:0] a, input logic [35:0] b);
    @(negedge clk);
    cyc++;
    check_out();
    in_valid = drv; mode = m; op = o; src_a = a; src_b = b;
    if (drv) begin
      q_exp.push_back(model(m, o, a, b)); q_t.push_back(cyc); q_o.push_back(o); q_m.push_back(m);
    end
  endtask

  function automatic logic [7:0] edge8(input int i);
    case (i)
      0: return 8'h00; 1: return 8'h01; 2: return 8'h02; 3: return 8'h7f;
      4: return 8'h80; 5: return 8'h81; 6: return 8'hfe; 7: return 8'hff;
      default: return 8'(i * 37 + 11);
    endcase
  endfunction

  function automatic logic [31:0] edge32(input int i);
    case (i % 8)
      0: return 32'h0000_0000; 1: return 32'h0000_0001; 2: return 32'h7fff_ffff;
      3: return 32'h8000_0000; 4: return 32'hffff_ffff; 5: return 32'h0000_ffff;
      6: return 32'h0000_8000; default: return 32'h7fff_8000;
    endcase
  endfunction

  function automatic logic [35:0] flagjunk(input logic [31:0] dv);
    return pack(dv, 4'($urandom));
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== 36'd0) begin
      errors++; $display("FAIL R10 reset got=%b/%h exp=0/0", out_valid, result);
    end
    rst_n = 1'b1;
    // R1 byte mode: every byte of a against edge bytes of b
    for (int o = 0; o < 8; o++)
      for (int x = 0; x < 256; x++)
        for (int yi = 0; yi < 16; yi++) begin
          logic [7:0] xb, yb;
          xb = 8'(x); yb = edge8(yi);
          step(1, 2'b10, 3'(o),
               flagjunk({~xb, xb + 8'd37, xb ^ 8'h5a, xb}),
               flagjunk({edge8((yi + 3) % 16), edge8((yi + 2) % 16), edge8((yi + 1) % 16), yb}));
        end
    // idle gap exercises R10 hold
    for (int i = 0; i < 6; i++) step(0, 2'b00, 3'd0, '0, '0);
    for (int m = 0; m < 2; m++)
      for (int o = 0; o < 8; o++)
        for (int i = 0; i < 1500; i++) begin
          logic [31:0] av, bv;
          av = (i < 64) ? edge32(i) : $urandom;
          bv = (i < 64) ? edge32(i / 8) : $urandom;
          if (i >= 64 && i < 128) begin av = {edge32(i)[15:0], edge32(i / 8)[15:0]}; bv = {edge32(i / 8)[15:0], edge32(i)[15:0]}; end
          step(1, 2'(m), 3'(o), flagjunk(av), flagjunk(bv));
          if (i % 97 == 0) step(0, 2'b00, 3'd0, '0, '0);
        end
    // mode 2'b11 behaves as byte mode (R1)
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 200; i++)
        step(1, 2'b11, 3'(o), flagjunk($urandom), flagjunk($urandom));
    for (int i = 0; i < 6; i++) step(0, 2'b00, 3'd0, '0, '0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule